// File: doc/BRIEF.md
# USB Endpoint Interrupt Aggregator

This block sits beside the endpoint logic of a seven-endpoint USB device function and folds each endpoint's packet events into one latched status bit per endpoint. Which events count depends on each endpoint's configured kind.

- A control endpoint reacts to all four of its event flags.
- An IN endpoint reacts only to the end of transmit-ready.
- An OUT endpoint reacts only to a received OUT packet.

A start-of-frame pulse latches a separate pending flag. Firmware reads the status bits and clears them by writing ones to a separate write-only acknowledge register. An enable register masks the status bits and the pending start-of-frame flag into a single level-sensitive interrupt request.

The CPU side is a simple register port with plain read and write strobes. No data stream crosses this block, so it has no valid/ready handshake. A write takes effect at the clock edge where `cpu_wr` is sampled high. `cpu_rdata` is registered and shows the addressed register one cycle after `cpu_rd`. It holds that value until the next read.

The register map is:

- Address 0: status.
- Address 1: acknowledge.
- Address 2: enable.
- Address 3: unused, reads as zero.

Top module: `usb_ep_irq_agg`

## Requirements
- R1: After reset the status bits, the enable register and the start-of-frame pending flag are all 0, and `irq` is low.
- R2: For an endpoint whose kind is control (code 0) or OUT (code 2), a 0-to-1 transition of its `ep_rx_out` bit sets its status bit. A 1-to-0 transition does not.
- R3: For an endpoint whose kind is control or IN (code 1), a 1-to-0 transition of its `ep_tx_rdy` bit sets its status bit. A 0-to-1 transition does not.
- R4: For a control endpoint only, a 0-to-1 transition of `ep_rx_setup` or of `ep_tx_done` sets its status bit. On IN, OUT or kind-3 endpoints, any flag not allowed for that kind leaves the status bit at 0.
- R5: A write to address 1 clears each status bit n (0..6) whose data bit n is 1, and leaves bits written 0 unchanged. Data bit 7 clears the start-of-frame pending flag.
- R6: When a set event and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R7: The enable register at address 2 is written with all eight data bits and reads back exactly what was written.
- R8: `irq` is high exactly when some status bit n has enable bit n set, or when the start-of-frame pending flag and enable bit 7 are both set. It follows a register change with no further delay.
- R9: A one-cycle `sof_pulse` sets the start-of-frame pending flag whatever the enable value. Bit 7 of the status read is always 0.
- R10: A read of address 1 or address 3 returns 0x00. Any read result appears on `cpu_rdata` in the cycle after `cpu_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ep_rx_out | input | 7 | Per-endpoint received-OUT-packet flag |
| ep_tx_rdy | input | 7 | Per-endpoint transmit-packet-ready flag |
| ep_rx_setup | input | 7 | Per-endpoint received-SETUP flag |
| ep_tx_done | input | 7 | Per-endpoint transmit-complete flag |
| ep_type | input | 14 | Two bits per endpoint (endpoint n at bits 2n+1:2n): 0 control, 1 IN, 2 OUT, 3 none |
| sof_pulse | input | 1 | One-cycle start-of-frame strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, active high |

## Verification
Timing for each stimulus is fixed, so the checks can sample at a known point.

- Flag event: a flag change applied before a rising edge is compared with the flag value registered at that edge. The status bit is therefore set at that same edge, and `irq` follows it combinationally.
- Acknowledge or enable write: it also takes effect at the edge where `cpu_wr` is sampled.
- Read: the value appears on `cpu_rdata` after the following edge.

The bench drives every input at the falling edge and samples the results at the next falling edge. A read is issued for one cycle and its data is sampled half a cycle after the capturing edge.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  typedef enum logic [1:0] {
    EP_KIND_CTRL = 2'd0,
    EP_KIND_IN   = 2'd1,
    EP_KIND_OUT  = 2'd2,
    EP_KIND_NONE = 2'd3
  } ep_kind_e;

  localparam int unsigned REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_ACK    = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_ENABLE = 2'd2;

endpackage

// File: rtl/ep_evt_detect.sv
module ep_evt_detect
  import usb_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rx_out,
  input  logic     tx_rdy,
  input  logic     rx_setup,
  input  logic     tx_done,
  input  ep_kind_e kind,
  output logic     set_evt
);

  logic rx_out_q;
  logic tx_rdy_q;
  logic rx_setup_q;
  logic tx_done_q;

  logic allow_out;
  logic allow_in;
  logic allow_ctl;

  logic rise_out;
  logic fall_rdy;
  logic rise_setup;
  logic rise_done;

  // Previous value of every flag, taken on every clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_out_q   <= 1'b0;
      tx_rdy_q   <= 1'b0;
      rx_setup_q <= 1'b0;
      tx_done_q  <= 1'b0;
    end else begin
      rx_out_q   <= rx_out;
      tx_rdy_q   <= tx_rdy;
      rx_setup_q <= rx_setup;
      tx_done_q  <= tx_done;
    end
  end

  always_comb begin
    allow_ctl = (kind == EP_KIND_CTRL);
    allow_out = allow_ctl || (kind == EP_KIND_OUT);
    allow_in  = allow_ctl || (kind == EP_KIND_IN);

    rise_out   = rx_out & ~rx_out_q;
    fall_rdy   = ~tx_rdy & tx_rdy_q;
    rise_setup = rx_setup & ~rx_setup_q;
    rise_done  = tx_done & ~tx_done_q;

    set_evt = (allow_out & rise_out)
            | (allow_in & fall_rdy)
            | (allow_ctl & (rise_setup | rise_done));
  end

  // R4
  endpoint_kind_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == EP_KIND_NONE) |-> !set_evt);

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned NUM_EP = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] set_evt,
  input  logic              sof_pulse,
  input  logic              ack_we,
  input  logic [NUM_EP:0]   ack_bits,
  output logic [NUM_EP-1:0] status,
  output logic              sof_pend
);

  logic [NUM_EP-1:0] clr_vec;

  always_comb begin
    clr_vec = ack_we ? ack_bits[NUM_EP-1:0] : '0;
  end

  // Set is applied after clear, so a coincident event survives.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else begin
      status <= (status & ~clr_vec) | set_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_pend <= 1'b0;
    end else if (sof_pulse) begin
      sof_pend <= 1'b1;
    end else if (ack_we && ack_bits[NUM_EP]) begin
      sof_pend <= 1'b0;
    end
  end

  // R2
  status_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(set_evt)) == '0));

  // R6
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_evt) |=> ((status & $past(set_evt)) == $past(set_evt)));

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && |(ack_bits[NUM_EP-1:0] & ~set_evt))
      |=> ((status & $past(ack_bits[NUM_EP-1:0] & ~set_evt)) == '0));

  // R9
  sof_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |=> sof_pend);

endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import usb_irq_pkg::*;
#(
  parameter int unsigned NUM_EP = 7,
  localparam int unsigned REG_W = NUM_EP + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_rd,
  input  logic                  cpu_wr,
  input  logic [REG_ADDR_W-1:0] cpu_addr,
  input  logic [REG_W-1:0]      cpu_wdata,
  input  logic [NUM_EP-1:0]     status,
  output logic [REG_W-1:0]      enable,
  output logic                  ack_we,
  output logic [REG_W-1:0]      ack_bits,
  output logic [REG_W-1:0]      cpu_rdata
);

  logic [REG_W-1:0] rd_mux;

  always_comb begin
    ack_we   = cpu_wr && (cpu_addr == ADDR_ACK);
    ack_bits = cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
    end else if (cpu_wr && (cpu_addr == ADDR_ENABLE)) begin
      enable <= cpu_wdata;
    end
  end

  always_comb begin
    unique case (cpu_addr)
      ADDR_STATUS: rd_mux = {1'b0, status};
      ADDR_ENABLE: rd_mux = enable;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rdata <= '0;
    end else if (cpu_rd) begin
      cpu_rdata <= rd_mux;
    end
  end

  // R9
  status_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == ADDR_STATUS) |=> !cpu_rdata[REG_W-1]);

  // R10
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == ADDR_ACK) |=> (cpu_rdata == '0));

  // R7
  enable_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr == ADDR_ENABLE) |=> $stable(enable));

endmodule

// File: rtl/usb_ep_irq_agg.sv
module usb_ep_irq_agg
  import usb_irq_pkg::*;
#(
  parameter int unsigned NUM_EP = 7,
  localparam int unsigned REG_W = NUM_EP + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EP-1:0]     ep_rx_out,
  input  logic [NUM_EP-1:0]     ep_tx_rdy,
  input  logic [NUM_EP-1:0]     ep_rx_setup,
  input  logic [NUM_EP-1:0]     ep_tx_done,
  input  logic [2*NUM_EP-1:0]   ep_type,
  input  logic                  sof_pulse,
  input  logic                  cpu_rd,
  input  logic                  cpu_wr,
  input  logic [REG_ADDR_W-1:0] cpu_addr,
  input  logic [REG_W-1:0]      cpu_wdata,
  output logic [REG_W-1:0]      cpu_rdata,
  output logic                  irq
);

  logic [NUM_EP-1:0] set_evt;
  logic [NUM_EP-1:0] status;
  logic              sof_pend;
  logic [REG_W-1:0]  enable;
  logic              ack_we;
  logic [REG_W-1:0]  ack_bits;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    ep_evt_detect u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_out   (ep_rx_out[g]),
      .tx_rdy   (ep_tx_rdy[g]),
      .rx_setup (ep_rx_setup[g]),
      .tx_done  (ep_tx_done[g]),
      .kind     (ep_kind_e'(ep_type[2*g +: 2])),
      .set_evt  (set_evt[g])
    );
  end

  irq_status_bank #(.NUM_EP(NUM_EP)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_evt   (set_evt),
    .sof_pulse (sof_pulse),
    .ack_we    (ack_we),
    .ack_bits  (ack_bits),
    .status    (status),
    .sof_pend  (sof_pend)
  );

  irq_cpu_port #(.NUM_EP(NUM_EP)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .status    (status),
    .enable    (enable),
    .ack_we    (ack_we),
    .ack_bits  (ack_bits),
    .cpu_rdata (cpu_rdata)
  );

  always_comb begin
    irq = (|(status & enable[NUM_EP-1:0])) | (sof_pend & enable[NUM_EP]);
  end

  // R8
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|status) || sof_pend));

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);

endmodule

// File: tb/usb_ep_irq_agg_tb_top.sv
module usb_ep_irq_agg_tb_top;

  localparam int NEP = 7;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NEP-1:0] ep_rx_out = '0;
  logic [NEP-1:0] ep_tx_rdy = '0;
  logic [NEP-1:0] ep_rx_setup = '0;
  logic [NEP-1:0] ep_tx_done = '0;
  logic [2*NEP-1:0] ep_type;
  logic           sof_pulse = 1'b0;
  logic           cpu_rd = 1'b0;
  logic           cpu_wr = 1'b0;
  logic [1:0]     cpu_addr = '0;
  logic [7:0]     cpu_wdata = '0;
  logic [7:0]     cpu_rdata;
  logic           irq;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  // ep0 ctrl, ep1 IN, ep2 OUT, ep3 ctrl, ep4 IN, ep5 OUT, ep6 ctrl
  assign ep_type = {2'd0, 2'd2, 2'd1, 2'd0, 2'd2, 2'd1, 2'd0};

  always #10 clk = ~clk;

  usb_ep_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n),
    .ep_rx_out(ep_rx_out), .ep_tx_rdy(ep_tx_rdy),
    .ep_rx_setup(ep_rx_setup), .ep_tx_done(ep_tx_done),
    .ep_type(ep_type), .sof_pulse(sof_pulse),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cpu_rd = 1'b1; cpu_addr = a;
    tick();
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    tick();
    cpu_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq", {7'd0, irq}, 8'h00);
    rd(2'd0, d); check("R1 status", d, 8'h00);
    rd(2'd2, d); check("R1 enable", d, 8'h00);
  endtask

  task automatic t_out_events();
    logic [7:0] d;
    ep_rx_out = 7'b0000111; tick();
    rd(2'd0, d); check("R2 rx_out rise ctrl/OUT, ignored on IN (R4)", d, 8'h05);
    wr(2'd1, 8'h05);
    ep_rx_out = '0; tick();
    rd(2'd0, d); check("R2 rx_out fall no set", d, 8'h00);
  endtask

  task automatic t_in_events();
    logic [7:0] d;
    ep_tx_rdy = 7'b0100010; tick();
    rd(2'd0, d); check("R3 tx_rdy rise no set", d, 8'h00);
    ep_tx_rdy = '0; tick();
    rd(2'd0, d); check("R3 tx_rdy fall IN set, OUT ignored (R4)", d, 8'h02);
    wr(2'd1, 8'h02);
  endtask

  task automatic t_ctrl_events();
    logic [7:0] d;
    ep_rx_setup = 7'b0011000; ep_tx_done = 7'b1000100; tick();
    rd(2'd0, d); check("R4 setup/done on ctrl only", d, 8'h48);
    ep_rx_setup = '0; ep_tx_done = '0; tick();
  endtask

  task automatic t_ack();
    logic [7:0] d;
    wr(2'd1, 8'h08);
    rd(2'd0, d); check("R5 partial ack", d, 8'h40);
    wr(2'd1, 8'h80);
    rd(2'd0, d); check("R5 ack bit7 leaves status", d, 8'h40);
    wr(2'd1, 8'h40);
    rd(2'd0, d); check("R5 ack clears", d, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] d;
    ep_rx_out[2] = 1'b1;
    wr(2'd1, 8'h04);
    rd(2'd0, d); check("R6 set wins over ack", d, 8'h04);
    ep_rx_out[2] = 1'b0;
    wr(2'd1, 8'h04);
    rd(2'd0, d); check("R6 later ack clears", d, 8'h00);
  endtask

  task automatic t_enable_irq();
    logic [7:0] d;
    wr(2'd2, 8'hA5);
    rd(2'd2, d); check("R7 enable readback", d, 8'hA5);
    ep_rx_out[0] = 1'b1; tick();
    check("R8 enabled bit raises irq", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h01);
    check("R8 ack drops irq", {7'd0, irq}, 8'h00);
    ep_rx_out[0] = 1'b0;
    ep_tx_rdy[1] = 1'b1; tick(); ep_tx_rdy[1] = 1'b0; tick();
    check("R8 masked bit no irq", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h02);
    check("R8 enabling pending bit raises irq", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h02);
  endtask

  task automatic t_sof();
    logic [7:0] d;
    wr(2'd2, 8'h00);
    sof_pulse = 1'b1; tick(); sof_pulse = 1'b0;
    check("R9 sof masked", {7'd0, irq}, 8'h00);
    rd(2'd0, d); check("R9 status bit7 zero", d, 8'h00);
    wr(2'd2, 8'h80);
    check("R9 latched sof raises irq", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h80);
    check("R5 ack bit7 clears sof", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_reads();
    logic [7:0] d;
    ep_rx_out[5] = 1'b1; tick();
    rd(2'd1, d); check("R10 ack reads zero", d, 8'h00);
    rd(2'd3, d); check("R10 addr3 reads zero", d, 8'h00);
    cpu_rd = 1'b1; cpu_addr = 2'd0; @(posedge clk); #1;
    cpu_rd = 1'b0;
    check("R10 read data one cycle later", cpu_rdata, 8'h20);
    tick();
    ep_rx_out[5] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_out_events();
    t_in_events();
    t_ctrl_events();
    t_ack();
    t_race();
    t_enable_irq();
    t_sof();
    t_reads();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule